// File: doc/BRIEF.md
# Serial Host Register Port

This block is a slave serial port through which a host reads and writes a small bank of control registers and a status register. The host frames each access with an active-low select, shifts a command bit, an address and a data byte in on a serial clock, and, for reads, receives the data byte back on a serial output. That output has its own enable so that a pad can float it. All four serial pins are sampled by the block's system clock, so the serial clock must run several times slower than that clock.

A static edge-select pin picks which serial clock edge the host uses to capture read data. Two monitored line conditions, loss of signal and network loopback, each set a sticky change flag whenever they toggle. While either flag is set, the block asks for attention on an active-low interrupt. That interrupt is modelled as a pull-low enable and the resolved pin level. The host silences it by writing zero to the flag bits.

Top module: `serial_host_port`

## Requirements
- R1: A frame is 16 serial clock rising edges while `csn` is low. Bit 0 is the command (1 = read, 0 = write), bits 1..7 are the address with its LSB first, and bits 8..15 are the data byte with its LSB first. `sdi` is sampled on the rising edge.
- R2: A write takes effect only after the 16th rising edge. If `csn` returns high earlier, the frame is dropped and no register changes.
- R3: On a read, the data byte leaves on `sdo` with its LSB first. With `edge_sel` high, each bit is stable at the rising edges 9 to 16. With `edge_sel` low, each bit is stable at the falling edges 9 to 16.
- R4: `sdo_oe` is low while `csn` is high, throughout a write frame, and during the first 8 bits of a read frame. It is high for the data part of a read frame.
- R5: Bits past the 16th in a frame are ignored. A frame counts only after `csn` has been seen high since reset.
- R6: Any toggle of `los_in` sets status flag bit 0, and any toggle of `nloop_in` sets status flag bit 1, in either direction. While either flag is set, `irq_oe` is 1 and `irq_n` is 0.
- R7: Writing address 0 clears each flag whose data bit is 0 and leaves alone each flag whose data bit is 1. Once both flags are clear, `irq_oe` returns to 0 and `irq_n` returns to 1. A toggle in the same cycle as a clear wins.
- R8: Reading address 0 returns the flags in bits 1:0, the live `los_in` level in bit 2, the live `nloop_in` level in bit 3, and zeros in bits 7:4. Writes never alter bits 7:2.
- R9: After reset, `sdo_oe` and `irq_oe` are 0, `irq_n` is 1, and both flags are clear. Both status inputs are taken as low at reset.
- R10: Addresses 1 to NREG-1 (15 by default) are plain read/write registers. Addresses at or above NREG read 0, and writes to them are ignored without aliasing onto lower addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csn | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| edge_sel | input | 1 | 1: read data valid at sclk rise; 0: at sclk fall |
| los_in | input | 1 | Loss-of-signal condition |
| nloop_in | input | 1 | Network-loopback condition |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Drive enable for sdo |
| irq_oe | output | 1 | Interrupt pull-low enable |
| irq_n | output | 1 | Resolved interrupt level, active low |

## Verification
Register reads are exercised under both edge-select settings. This shows whether data is launched half a serial clock ahead of the capturing edge, or one whole bit late or early. Frames cut short at 10 and 15 bits separate a commit on the last edge from a commit on an earlier one. An over-long frame with trailing ones shows whether the shifter keeps running past 16 bits. Writes to address 100 and reads of address 4 reveal any truncated address decode. The status inputs are toggled both up and down, and the flags are cleared one at a time. This shows that the interrupt follows both flags together, that change detection works in both directions, and that the live bits ignore writes.

// File: rtl/shp_pkg.sv
package shp_pkg;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int HDR_BITS   = 1 + ADDR_W;
  localparam int FRAME_BITS = HDR_BITS + DATA_W;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/shp_sync.sv
module shp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/shp_frame.sv
module shp_frame
  import shp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              sdi_s,
  input  logic              edge_sel_s,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [ADDR_W-1:0] addr,
  output wr_req_t           wr_q,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam int SR_IW = $clog2(FRAME_BITS);
  localparam int BS_W  = $clog2(DATA_W);

  logic                  sclk_d, armed;
  logic [CNT_W-1:0]      cnt;
  logic [FRAME_BITS-1:0] sr;
  logic                  rise, fall, launch, live, in_data;
  logic [BS_W-1:0]       bsel;

  assign rise    = sclk_s & ~sclk_d;
  assign fall    = ~sclk_s & sclk_d;
  assign launch  = edge_sel_s ? fall : rise;
  assign live    = armed & ~csn_s;
  assign in_data = (cnt >= CNT_W'(HDR_BITS)) && (cnt < CNT_W'(FRAME_BITS));
  assign bsel    = BS_W'(cnt - CNT_W'(HDR_BITS));
  assign addr    = sr[ADDR_W:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      armed  <= 1'b0;
      cnt    <= '0;
      sr     <= '0;
      wr_q   <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      sclk_d  <= sclk_s;
      wr_q.en <= 1'b0;
      if (csn_s) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed && rise && cnt < CNT_W'(FRAME_BITS)) begin
        sr[cnt[SR_IW-1:0]] <= sdi_s;
        cnt                <= cnt + 1'b1;
        if (cnt == CNT_W'(FRAME_BITS - 1) && !sr[0]) begin
          wr_q.en   <= 1'b1;
          wr_q.addr <= sr[ADDR_W:1];
          wr_q.data <= {sdi_s, sr[FRAME_BITS-2:HDR_BITS]};
        end
      end
      if (live && launch && in_data) sdo <= rd_byte[bsel];
      sdo_oe <= live & sr[0] & (cnt >= CNT_W'(HDR_BITS));
    end
  end

  assert_oe_idle_R4: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> !sdo_oe);
  assert_cnt_cap_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(FRAME_BITS));
  assert_wr_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
    wr_q.en |-> $past(!csn_s && armed));
endmodule

// File: rtl/shp_status.sv
module shp_status
  import shp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              los_s,
  input  logic              nlp_s,
  input  logic              clr_en,
  input  logic [1:0]        clr_keep,
  output logic [DATA_W-1:0] stat_byte,
  output logic              irq_oe,
  output logic              irq_n
);
  logic [1:0] prev, flag, chg;

  assign chg       = {nlp_s, los_s} ^ prev;
  assign stat_byte = {{(DATA_W-4){1'b0}}, nlp_s, los_s, flag};

  always_ff @(posedge clk) begin
    if (rst) begin
      prev   <= 2'b00;
      flag   <= 2'b00;
      irq_oe <= 1'b0;
      irq_n  <= 1'b1;
    end else begin
      prev   <= {nlp_s, los_s};
      flag   <= (flag & (clr_en ? clr_keep : 2'b11)) | chg;
      irq_oe <= |flag;
      irq_n  <= ~|flag;
    end
  end

  assert_los_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (los_s != $past(los_s)) |-> ##1 flag[0]);
  assert_irq_on_R6: assert property (@(posedge clk) disable iff (rst)
    (|flag) |=> (irq_oe && !irq_n));
  assert_irq_release_R7: assert property (@(posedge clk) disable iff (rst)
    (flag == 2'b00) |=> (!irq_oe && irq_n));
endmodule

// File: rtl/shp_regs.sv
module shp_regs #(
  parameter int NREG = 16,
  parameter int DW   = 8,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/serial_host_port.sv
module serial_host_port
  import shp_pkg::*;
#(
  parameter int NREG      = 16,
  parameter int STAT_ADDR = 0,
  parameter int SYNC_LEN  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic csn,
  input  logic sclk,
  input  logic sdi,
  input  logic edge_sel,
  input  logic los_in,
  input  logic nloop_in,
  output logic sdo,
  output logic sdo_oe,
  output logic irq_oe,
  output logic irq_n
);
  localparam int IW = $clog2(NREG);

  logic [5:0]        pins_s;
  logic              sclk_s, csn_s, sdi_s, es_s, los_s, nlp_s;
  logic [ADDR_W-1:0] addr;
  wr_req_t           wr_q;
  logic [DATA_W-1:0] rd_byte, mem_rdata, stat_byte;
  logic              wr_hit, wr_stat, rd_stat_q, rd_in_q;

  shp_sync #(.W(6), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst(rst),
    .d({nloop_in, los_in, edge_sel, sdi, csn, sclk}),
    .q(pins_s)
  );
  assign {nlp_s, los_s, es_s, sdi_s, csn_s, sclk_s} = pins_s;

  shp_frame u_frame (
    .clk(clk), .rst(rst), .sclk_s(sclk_s), .csn_s(csn_s), .sdi_s(sdi_s),
    .edge_sel_s(es_s), .rd_byte(rd_byte), .addr(addr), .wr_q(wr_q),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  assign wr_hit  = wr_q.en && (int'(wr_q.addr) < NREG) && (int'(wr_q.addr) != STAT_ADDR);
  assign wr_stat = wr_q.en && (int'(wr_q.addr) == STAT_ADDR);

  shp_regs #(.NREG(NREG), .DW(DATA_W)) u_regs (
    .clk(clk), .we(wr_hit), .waddr(wr_q.addr[IW-1:0]), .wdata(wr_q.data),
    .raddr(addr[IW-1:0]), .rdata(mem_rdata)
  );

  shp_status u_status (
    .clk(clk), .rst(rst), .los_s(los_s), .nlp_s(nlp_s),
    .clr_en(wr_stat), .clr_keep(wr_q.data[1:0]),
    .stat_byte(stat_byte), .irq_oe(irq_oe), .irq_n(irq_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_stat_q <= 1'b0;
      rd_in_q   <= 1'b0;
    end else begin
      rd_stat_q <= (int'(addr) == STAT_ADDR);
      rd_in_q   <= (int'(addr) < NREG);
    end
  end

  assign rd_byte = rd_stat_q ? stat_byte : (rd_in_q ? mem_rdata : '0);

  assert_oob_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (!rd_in_q && !rd_stat_q) |-> (rd_byte == '0));
endmodule

// File: tb/serial_host_port_tb_top.sv
module serial_host_port_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic clk = 1'b0;
  logic rst, csn, sclk, sdi, edge_sel, los_in, nloop_in;
  logic sdo, sdo_oe, irq_oe, irq_n;

  int vec = 0;
  int bad = 0;
  int csn_hi = 0;
  bit done = 1'b0;

  logic [7:0] mm [int];
  logic [1:0] fl = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_host_port dut_i (
    .clk(clk), .rst(rst), .csn(csn), .sclk(sclk), .sdi(sdi),
    .edge_sel(edge_sel), .los_in(los_in), .nloop_in(nloop_in),
    .sdo(sdo), .sdo_oe(sdo_oe), .irq_oe(irq_oe), .irq_n(irq_n)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // per-clock: select high for a while -> output floated (R4); irq pin pair coherent (R6)
  always @(negedge clk) begin
    if (rst || !csn) csn_hi = 0;
    else csn_hi++;
    if (!rst && !done) begin
      if (csn_hi >= 4) chk("R4", "sdo_oe idle", {31'd0, sdo_oe}, 32'd0);
      chk("R6", "irq pair", {31'd0, irq_n}, {31'd0, ~irq_oe});
    end
  end

  task automatic frame(input bit rd, input logic [6:0] a, input logic [7:0] d,
                       input int nbits, input bit extra, output logic [7:0] q);
    logic [15:0] f;
    f = {d, a, rd};
    q = 8'h00;
    csn = 1'b0;
    idle(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? f[i] : extra;
      idle(HALF);
      if (rd && edge_sel && i >= 8 && i < 16) begin
        q[i-8] = sdo;
        chk("R4", "oe read data", {31'd0, sdo_oe}, 32'd1);
      end
      if ((!rd || i < 8) && i < 16) chk("R4", "oe header/write", {31'd0, sdo_oe}, 32'd0);
      sclk = 1'b1;
      idle(HALF);
      if (rd && !edge_sel && i >= 8 && i < 16) begin
        q[i-8] = sdo;
        chk("R4", "oe read data", {31'd0, sdo_oe}, 32'd1);
      end
      sclk = 1'b0;
    end
    idle(HALF);
    csn = 1'b1;
    idle(2*HALF);
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    if (a == 0) return {4'd0, nloop_in, los_in, fl};
    if (a < 16) return mm[a];
    return 8'h00;
  endfunction

  task automatic do_wr(input int a, input logic [7:0] d);
    logic [7:0] q;
    frame(1'b0, 7'(a), d, 16, 1'b0, q);
    if (a == 0) fl = fl & d[1:0];
    else if (a < 16) mm[a] = d;
  endtask

  task automatic do_rd(input int a, input string req);
    logic [7:0] q;
    frame(1'b1, 7'(a), 8'h00, 16, 1'b0, q);
    chk(req, $sformatf("read addr %0d", a), {24'd0, q}, {24'd0, exp_rd(a)});
  endtask

  task automatic chk_irq(input string req, input bit on);
    chk(req, "irq_oe", {31'd0, irq_oe}, {31'd0, on});
    chk(req, "irq_n", {31'd0, irq_n}, {31'd0, !on});
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vec++;
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] q;
    rst = 1'b1; csn = 1'b1; sclk = 1'b0; sdi = 1'b0;
    edge_sel = 1'b1; los_in = 1'b0; nloop_in = 1'b0;
    idle(5);
    rst = 1'b0;
    idle(6);
    // R9 reset state
    chk("R9", "sdo_oe", {31'd0, sdo_oe}, 32'd0);
    chk_irq("R9", 1'b0);

    // R1 / R3 with data valid at rising edges
    do_wr(5, 8'hA5);
    do_rd(5, "R1");
    do_wr(9, 8'h5A);
    do_rd(9, "R3");
    // R3 with data valid at falling edges
    edge_sel = 1'b0;
    idle(4);
    do_wr(12, 8'h3C);
    do_rd(12, "R3");
    do_wr(4, 8'h11);
    do_rd(4, "R1");
    do_rd(5, "R3");
    edge_sel = 1'b1;
    idle(4);

    // R2: truncated frames must not write
    frame(1'b0, 7'd5, 8'hFF, 10, 1'b0, q);
    frame(1'b0, 7'd5, 8'hFF, 15, 1'b0, q);
    do_rd(5, "R2");

    // R5: bits beyond 16 ignored
    frame(1'b0, 7'd7, 8'h81, 20, 1'b1, q);
    mm[7] = 8'h81;
    do_rd(7, "R5");

    // R10: out-of-range address
    do_wr(100, 8'h77);
    do_rd(100, "R10");
    do_rd(4, "R10");

    // R6 / R8 status
    los_in = 1'b1; fl[0] = 1'b1;
    idle(10);
    chk_irq("R6", 1'b1);
    do_rd(0, "R8");
    nloop_in = 1'b1; fl[1] = 1'b1;
    idle(10);
    do_rd(0, "R8");
    // R7 clear one at a time
    do_wr(0, 8'hFE);
    idle(4);
    chk_irq("R7", 1'b1);
    do_rd(0, "R7");
    do_wr(0, 8'hFD);
    idle(4);
    chk_irq("R7", 1'b0);
    do_rd(0, "R8");
    // R6 falling toggle also flags
    los_in = 1'b0; fl[0] = 1'b1;
    idle(10);
    chk_irq("R6", 1'b1);
    edge_sel = 1'b0;
    idle(4);
    do_rd(0, "R6");
    do_wr(0, 8'h00);
    idle(4);
    chk_irq("R7", 1'b0);
    do_rd(0, "R8");
    idle(10);
    finish_run();
  end
endmodule